// File: doc/BRIEF.md
# Paging Codeword Sync and Address Matcher

This block sits behind a clock-recovery stage in a radio paging receiver. It takes one recovered bit at a time, each marked by a bit-valid strobe. It hunts for the 32-bit batch sync word on every bit. Once the sync word is found, it locks to the batch structure: each batch is one sync slot followed by sixteen codeword slots, grouped as eight two-codeword frames. While locked, the block tracks which frame and slot the incoming bits belong to.

Four 18-bit identities are programmed as two pairs, A and B. Each pair has its own 3-bit frame number, and an address codeword is compared against a pair only in that frame. On a match the block raises data-valid and sends a short address record on a strobed serial output: which identity matched, then the two function bits. It then forwards the 20 payload bits of every message codeword that follows. The message carries on across an intervening sync slot. It ends at the next address or idle codeword.

While locked, a receiver-enable output keeps the radio off outside the slots the block needs. An out-of-range flag reports a long absence of the sync word.

The lock state machine has three states:
- ST_HUNT: searching bit by bit for the sync word.
- ST_SEARCH: locked, waiting for an address.
- ST_MESSAGE: locked, a message is in progress.

Its transitions are:
- hunt-lock: ST_HUNT to ST_SEARCH.
- address-hit: ST_SEARCH to ST_MESSAGE, or ST_MESSAGE back into ST_MESSAGE.
- message-end: ST_MESSAGE to ST_SEARCH.
- double-miss: ST_SEARCH or ST_MESSAGE to ST_HUNT.

The serializer has its own three states:
- SER_IDLE.
- SER_STROBE: announces a bit.
- SER_DRIVE: holds the bit.

Its transitions are load (any state to SER_STROBE), advance (SER_STROBE to SER_DRIVE), next (SER_DRIVE to SER_STROBE) and done (SER_DRIVE to SER_IDLE).

Top module: `pg_sync_matcher`

## Requirements
- R1: When `invert` is 1, every received bit is complemented before any comparison, so an inverted line locks and matches exactly as a true line does with `invert` at 0.
- R2: In ST_HUNT, the last 32 received bits are compared on every valid bit against 0x7CD215D8, with the first bit received as the MSB. On a match the block locks, and the next codeword is slot 1, which is the first codeword of frame 0.
- R3: While locked, slots run 0 to 16 and then wrap to 0. Slot 0 is the sync slot, and slot s (1 to 16) belongs to frame (s-1)/2.
- R4: A codeword is an address when its first bit is 0. Its bits 2 to 19 are compared with an identity only in the slot whose frame equals that identity's pair frame. The idle codeword 0x7A89C197 never matches.
- R5: On a match, a 4-bit record is sent MSB first. Its first two bits are the identity code: A1=00, A2=01, B1=10, B2=11. When several identities match, the highest code wins. The record's last two bits are codeword bits 20 and 21, in that order.
- R6: While a message is in progress, each codeword whose first bit is 1 has its bits 2 to 21 sent MSB first. A sync slot does not end the message.
- R7: `data_valid` rises at the clock edge that takes the last bit of the matching codeword. It falls at the edge that takes the last bit of a following non-matching address or idle codeword.
- R8: For each output bit, `data_strobe` is high for one cycle. `data_out` takes the new bit on the next cycle and changes at no other time.
- R9: `rx_en` is high in ST_HUNT. While locked, it is high only in the sync slot, in the slots of frame_a and frame_b, and while `data_valid` is high.
- R10: One wrong sync slot keeps the lock. Two consecutive wrong sync slots return the block to ST_HUNT.
- R11: `out_of_range` rises when NO_SYNC_BATCHES×544 valid bits have arrived since reset or since the last sync word was seen. It clears when a sync word is seen.
- R12: Clock cycles without `bit_vld` advance neither the bit position nor the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bit_in | input | 1 | recovered serial bit |
| bit_vld | input | 1 | marks the cycle in which bit_in is taken |
| invert | input | 1 | complement the received bits |
| id_a1 | input | 18 | identity A1 |
| id_a2 | input | 18 | identity A2 |
| id_b1 | input | 18 | identity B1 |
| id_b2 | input | 18 | identity B2 |
| frame_a | input | 3 | frame checked for pair A |
| frame_b | input | 3 | frame checked for pair B |
| data_out | output | 1 | serial record and message bits |
| data_strobe | output | 1 | one-cycle pulse announcing the next data_out bit |
| data_valid | output | 1 | a matched message is in progress |
| rx_en | output | 1 | receiver power enable |
| out_of_range | output | 1 | no sync word for the configured number of batches |

## Verification
State flags such as `data_valid` and `rx_en` change at the edge that takes a codeword's last bit. The bench drives each bit for one cycle and samples at the following falling edge, so these flags are read as soon as the send task returns. A serial bit follows its strobe by exactly one cycle. The bench therefore records `data_out` at the falling edge after any cycle where the strobe was seen, and compares the collected record only after a fixed drain gap with no bits. That same gap shows that idle cycles do not move the slot count. The range flag is read one bit before and exactly at the threshold count.

// File: rtl/pg_pkg.sv
package pg_pkg;
    localparam int CW_W    = 32;
    localparam int ID_W    = 18;
    localparam int MSG_W   = 20;
    localparam int FRAMES  = 8;
    localparam int FRAME_W = $clog2(FRAMES);
    localparam int SLOTS   = 2 * FRAMES + 1;
    localparam logic [CW_W-1:0] SYNC_WORD = 32'h7CD215D8;
    localparam logic [CW_W-1:0] IDLE_WORD = 32'h7A89C197;

    typedef enum logic [1:0] {ST_HUNT, ST_SEARCH, ST_MESSAGE} lock_state_e;
    typedef enum logic [1:0] {SER_IDLE, SER_STROBE, SER_DRIVE} ser_state_e;
endpackage

// File: rtl/pg_front.sv
module pg_front
    import pg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_in,
    input  logic            bit_vld,
    input  logic            invert,
    output logic [CW_W-1:0] word_now
);
    logic [CW_W-1:0] hist;
    logic            cond_bit;

    assign cond_bit = bit_in ^ invert;          // R1
    assign word_now = {hist[CW_W-2:0], cond_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hist <= '0;
        else if (bit_vld) hist <= word_now;
    end
endmodule

// File: rtl/pg_id_match.sv
module pg_id_match #(
    parameter int N_IDS   = 4,
    parameter int ID_W    = 18,
    parameter int FRAME_W = 3,
    parameter int CODE_W  = $clog2(N_IDS)
) (
    input  logic [N_IDS*ID_W-1:0]         ids,
    input  logic [(N_IDS/2)*FRAME_W-1:0]  frames,
    input  logic [FRAME_W-1:0]            cur_frame,
    input  logic [ID_W-1:0]               addr,
    output logic                          hit,
    output logic [CODE_W-1:0]             code
);
    logic [N_IDS-1:0] eq;

    for (genvar i = 0; i < N_IDS; i++) begin : g_cmp
        assign eq[i] = (ids[i*ID_W +: ID_W] == addr) &&
                       (frames[(i/2)*FRAME_W +: FRAME_W] == cur_frame);
    end

    always_comb begin
        hit  = |eq;
        code = '0;
        for (int i = 0; i < N_IDS; i++)
            if (eq[i]) code = CODE_W'(i);       // highest index wins, R5
    end
endmodule

// File: rtl/pg_serializer.sv
module pg_serializer
    import pg_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    output logic              dout,
    output logic              dstrobe
);
    ser_state_e        st, st_nx;
    logic [DATA_W-1:0] sh;
    logic [LEN_W-1:0]  rem;

    always_comb begin
        st_nx = st;
        unique case (st)
            SER_IDLE:   st_nx = SER_IDLE;
            SER_STROBE: st_nx = SER_DRIVE;
            SER_DRIVE:  st_nx = (rem == '0) ? SER_IDLE : SER_STROBE;
            default:    st_nx = SER_IDLE;
        endcase
        if (load) st_nx = SER_STROBE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SER_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            rem  <= '0;
            dout <= 1'b0;
        end else if (load) begin
            sh  <= data;
            rem <= len;
        end else if (st == SER_STROBE) begin
            dout <= sh[DATA_W-1];
            sh   <= sh << 1;
            rem  <= rem - 1'b1;
        end
    end

    assign dstrobe = (st == SER_STROBE);

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dstrobe |=> $stable(dout)); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dstrobe |=> !dstrobe); // R8
endmodule

// File: rtl/pg_sync_matcher.sv
module pg_sync_matcher
    import pg_pkg::*;
#(
    parameter int NO_SYNC_BATCHES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              invert,
    input  logic [ID_W-1:0]   id_a1,
    input  logic [ID_W-1:0]   id_a2,
    input  logic [ID_W-1:0]   id_b1,
    input  logic [ID_W-1:0]   id_b2,
    input  logic [FRAME_W-1:0] frame_a,
    input  logic [FRAME_W-1:0] frame_b,
    output logic              data_out,
    output logic              data_strobe,
    output logic              data_valid,
    output logic              rx_en,
    output logic              out_of_range
);
    localparam int BIT_W       = $clog2(CW_W);
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int N_IDS       = 4;
    localparam int CODE_W      = $clog2(N_IDS);
    localparam int LEN_W       = $clog2(MSG_W + 1);
    localparam int REC_W       = CODE_W + 2;
    localparam int RANGE_LIMIT = NO_SYNC_BATCHES * SLOTS * CW_W;
    localparam int RANGE_W     = $clog2(RANGE_LIMIT + 1);

    lock_state_e          st, st_nx;
    logic [BIT_W-1:0]     bit_cnt;
    logic [SLOT_W-1:0]    slot, slot_m1;
    logic                 miss;
    logic [RANGE_W-1:0]   quiet_cnt;
    logic [CW_W-1:0]      word;
    logic [FRAME_W-1:0]   cur_frame;
    logic                 id_hit;
    logic [CODE_W-1:0]    id_code;
    logic                 cw_done, sync_slot, is_sync, is_msg;
    logic                 hunt_lock, sync_ok, sync_miss, data_cw, addr_hit, sync_seen;
    logic                 ser_load;
    logic [MSG_W-1:0]     ser_data;
    logic [LEN_W-1:0]     ser_len;

    pg_front u_front (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .invert(invert), .word_now(word)
    );

    assign slot_m1   = slot - 1'b1;
    assign cur_frame = FRAME_W'(slot_m1 >> 1);                      // R3

    pg_id_match #(.N_IDS(N_IDS), .ID_W(ID_W), .FRAME_W(FRAME_W)) u_match (
        .ids({id_b2, id_b1, id_a2, id_a1}),
        .frames({frame_b, frame_a}),
        .cur_frame(cur_frame),
        .addr(word[CW_W-2 -: ID_W]),
        .hit(id_hit),
        .code(id_code)
    );

    assign is_sync   = (word == SYNC_WORD);
    assign is_msg    = word[CW_W-1];
    assign sync_slot = (slot == '0);
    assign cw_done   = bit_vld && (st != ST_HUNT) && (bit_cnt == BIT_W'(CW_W - 1));
    assign hunt_lock = (st == ST_HUNT) && bit_vld && is_sync;
    assign sync_ok   = cw_done && sync_slot && is_sync;
    assign sync_miss = cw_done && sync_slot && !is_sync;
    assign data_cw   = cw_done && !sync_slot;
    assign addr_hit  = data_cw && !is_msg && (word != IDLE_WORD) && id_hit;   // R4
    assign sync_seen = hunt_lock || sync_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HUNT;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HUNT:    if (hunt_lock) st_nx = ST_SEARCH;
            ST_SEARCH:  if (sync_miss && miss) st_nx = ST_HUNT;
                        else if (addr_hit)    st_nx = ST_MESSAGE;
            ST_MESSAGE: if (sync_miss && miss) st_nx = ST_HUNT;
                        else if (data_cw && !is_msg && !addr_hit) st_nx = ST_SEARCH;
            default:    st_nx = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        ser_load   = 1'b0;
        ser_data   = '0;
        ser_len    = '0;
        data_valid = (st == ST_MESSAGE);
        rx_en      = 1'b1;
        unique case (st)
            ST_HUNT: begin
                rx_en = 1'b1;
            end
            ST_SEARCH, ST_MESSAGE: begin
                rx_en = sync_slot || (cur_frame == frame_a) ||
                        (cur_frame == frame_b) || (st == ST_MESSAGE);
                if (addr_hit) begin
                    ser_load = 1'b1;
                    ser_data = {id_code, word[CW_W-2-ID_W -: 2], {(MSG_W-REC_W){1'b0}}};
                    ser_len  = LEN_W'(REC_W);
                end else if ((st == ST_MESSAGE) && data_cw && is_msg) begin
                    ser_load = 1'b1;
                    ser_data = word[CW_W-2 -: MSG_W];
                    ser_len  = LEN_W'(MSG_W);
                end
            end
            default: rx_en = 1'b1;
        endcase
    end

    // slot tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            slot    <= '0;
            miss    <= 1'b0;
        end else if (hunt_lock) begin
            bit_cnt <= '0;
            slot    <= SLOT_W'(1);
            miss    <= 1'b0;
        end else if ((st != ST_HUNT) && bit_vld) begin
            if (cw_done) begin
                bit_cnt <= '0;
                slot    <= (slot == SLOT_W'(SLOTS - 1)) ? '0 : slot + 1'b1;
                if (sync_slot) miss <= !is_sync;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // loss-of-sync timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt    <= '0;
            out_of_range <= 1'b0;
        end else if (sync_seen) begin
            quiet_cnt    <= '0;
            out_of_range <= 1'b0;
        end else if (bit_vld && (quiet_cnt != RANGE_W'(RANGE_LIMIT))) begin
            quiet_cnt <= quiet_cnt + 1'b1;
            if (quiet_cnt == RANGE_W'(RANGE_LIMIT - 1)) out_of_range <= 1'b1;
        end
    end

    pg_serializer #(.DATA_W(MSG_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .data(ser_data), .len(ser_len),
        .dout(data_out), .dstrobe(data_strobe)
    );

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= SLOT_W'(SLOTS - 1)); // R3
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(slot) && $stable(bit_cnt))); // R12
    AST_LOCK_START: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_lock |=> (slot == SLOT_W'(1) && !data_valid)); // R2
    AST_RANGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_seen |=> !out_of_range); // R11
    AST_DOUBLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_miss && miss) |=> (rx_en && !data_valid)); // R10
endmodule

// File: tb/pg_sync_matcher_tb.sv
module pg_sync_matcher_tb;
    import pg_pkg::*;

    localparam int NSB        = 3;
    localparam int RANGE_BITS = NSB * 17 * 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, bit_in = 1'b0, bit_vld = 1'b0, invert = 1'b0;
    logic [17:0] id_a1, id_a2, id_b1, id_b2;
    logic [2:0]  fa = 3'd2, fb = 3'd7;
    logic data_out, data_strobe, data_valid, rx_en, out_of_range;

    pg_sync_matcher #(.NO_SYNC_BATCHES(NSB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld), .invert(invert),
        .id_a1(id_a1), .id_a2(id_a2), .id_b1(id_b1), .id_b2(id_b2),
        .frame_a(fa), .frame_b(fb),
        .data_out(data_out), .data_strobe(data_strobe), .data_valid(data_valid),
        .rx_en(rx_en), .out_of_range(out_of_range)
    );

    int   n_cmp = 0, n_bad = 0;
    logic inv_line = 1'b0;
    logic msg_on = 1'b0;

    logic        pend = 1'b0;
    logic [31:0] cap = '0;
    int          ncap = 0;
    always @(negedge clk) begin
        if (pend) begin
            cap  = {cap[30:0], data_out};
            ncap = ncap + 1;
        end
        pend = data_strobe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b ^ inv_line;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) send_bit(w[i]);
    endtask

    function automatic logic exp_rx(input int s);
        int f = (s - 1) / 2;
        return (s == 0) || (f == int'(fa)) || (f == int'(fb));
    endfunction

    task automatic slot_word(input int s, input logic [31:0] w);
        chk("R3/R9/R12 rx_en", 32'(rx_en), 32'(exp_rx(s) || msg_on));
        send_word(w);
    endtask

    task automatic drain(input string req, input int n, input logic [31:0] exp);
        repeat (48) @(negedge clk);
        chk(req, 32'(ncap), 32'(n));
        chk(req, cap & ((32'd1 << n) - 1), exp);
        @(posedge clk);
        ncap = 0;
        cap  = '0;
    endtask

    function automatic logic [31:0] mk_addr(input logic [17:0] id, input logic [1:0] fn);
        return {1'b0, id, fn, 11'b0};
    endfunction

    function automatic logic [31:0] mk_msg(input logic [19:0] m);
        return {1'b1, m, 11'b0};
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        id_a1 = 18'h12345; id_a2 = 18'h0ABCD; id_b1 = 18'h2F0F0; id_b2 = 18'h31111;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset rx_en", 32'(rx_en), 32'd1);
        chk("R7 reset data_valid", 32'(data_valid), 32'd0);
        chk("R11 reset out_of_range", 32'(out_of_range), 32'd0);
        chk("R8 reset strobe", 32'(data_strobe), 32'd0);

        // R2: garbage then sync at an odd alignment
        send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        send_word(SYNC_WORD);
        chk("R2 no valid on lock", 32'(data_valid), 32'd0);
        chk("R2 slot1 rx off", 32'(rx_en), 32'd0);

        // batch 1: A1 match in frame 2, message, idle end
        for (int s = 1; s <= 16; s++) begin
            if (s == 5) begin
                slot_word(s, mk_addr(id_a1, 2'b10));
                chk("R7 valid on match", 32'(data_valid), 32'd1);
                msg_on = 1'b1;
                drain("R5/R8 A1 record", 4, 32'b0010);
            end else if (s == 6) begin
                slot_word(s, mk_msg(20'hABCDE));
                drain("R6/R8 message bits", 20, 32'hABCDE);
            end else if (s == 7) begin
                slot_word(s, IDLE_WORD);
                chk("R7 idle ends message", 32'(data_valid), 32'd0);
                msg_on = 1'b0;
            end else begin
                slot_word(s, IDLE_WORD);
            end
        end

        // batch 2: wrong frame, idle-shaped identity, B priority
        slot_word(0, SYNC_WORD);
        id_b2 = id_b1;
        for (int s = 1; s <= 16; s++) begin
            if (s == 3) begin
                slot_word(s, mk_addr(id_a1, 2'b00));
                chk("R4 wrong frame ignored", 32'(data_valid), 32'd0);
            end else if (s == 5) begin
                id_a1 = IDLE_WORD[30:13];
                slot_word(s, IDLE_WORD);
                chk("R4 idle never matches", 32'(data_valid), 32'd0);
                id_a1 = 18'h12345;
            end else if (s == 16) begin
                slot_word(s, mk_addr(id_b1, 2'b01));
                chk("R7 valid on B match", 32'(data_valid), 32'd1);
                msg_on = 1'b1;
                drain("R5 priority record", 4, 32'b1101);
            end else begin
                slot_word(s, IDLE_WORD);
            end
        end
        id_b2 = 18'h31111;

        // batch 3: message across sync, end on address, A2 match
        slot_word(0, SYNC_WORD);
        chk("R6 sync keeps valid", 32'(data_valid), 32'd1);
        for (int s = 1; s <= 16; s++) begin
            if (s == 1) begin
                slot_word(s, mk_msg(20'h13579));
                drain("R6 message after sync", 20, 32'h13579);
            end else if (s == 2) begin
                slot_word(s, mk_addr(id_a2, 2'b11));
                chk("R7 address ends message", 32'(data_valid), 32'd0);
                msg_on = 1'b0;
            end else if (s == 5) begin
                slot_word(s, mk_addr(id_a2, 2'b00));
                chk("R7 valid on A2", 32'(data_valid), 32'd1);
                msg_on = 1'b1;
                drain("R5 A2 record", 4, 32'b0100);
            end else if (s == 6) begin
                slot_word(s, IDLE_WORD);
                chk("R7 idle ends A2", 32'(data_valid), 32'd0);
                msg_on = 1'b0;
            end else begin
                slot_word(s, IDLE_WORD);
            end
        end

        // batch 4: one bad sync slot keeps lock
        slot_word(0, SYNC_WORD ^ 32'h1);
        for (int s = 1; s <= 16; s++) slot_word(s, IDLE_WORD);
        // batch 5: second bad sync slot drops lock
        slot_word(0, SYNC_WORD ^ 32'h1);
        chk("R10 hunting after two misses", 32'(rx_en), 32'd1);
        send_word(IDLE_WORD);
        chk("R10 still hunting", 32'(rx_en), 32'd1);

        // R1: inverted line
        invert = 1'b1;
        inv_line = 1'b1;
        send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(0);
        send_word(SYNC_WORD);
        chk("R1 locked on inverted line", 32'(rx_en), 32'd0);
        for (int s = 1; s <= 5; s++) begin
            if (s == 5) begin
                slot_word(s, mk_addr(id_a1, 2'b01));
                chk("R1 match on inverted line", 32'(data_valid), 32'd1);
                drain("R1 record", 4, 32'b0001);
            end else begin
                slot_word(s, IDLE_WORD);
            end
        end

        // R11: range timer
        invert = 1'b0;
        inv_line = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < RANGE_BITS - 1; i++) send_bit(0);
        chk("R11 below threshold", 32'(out_of_range), 32'd0);
        send_bit(0);
        chk("R11 at threshold", 32'(out_of_range), 32'd1);
        send_word(SYNC_WORD);
        chk("R11 cleared by sync", 32'(out_of_range), 32'd0);

        summary();
        $finish;
    end
endmodule